// File: doc/BRIEF.md
# Dual-Bus Pointer Address Generator

This block produces two data-memory addresses in every cycle, one for an X memory bus and one for a Y memory bus, so that a signal-processing datapath can fetch two operands at once. Each side owns two 16-bit pointer registers and one 16-bit index register. Per cycle and per side, a select bit picks which of the two pointers drives the bus, and a two-bit mode field picks how that pointer is changed afterwards. The pointer can stay as it is, step forward by two bytes, or advance by that side's index register.

The bus carries only address bits 15 down to 1, so every access is 16-bit-word aligned. The address presented in a cycle is the pointer's value before its update. The updated value is written back at the clock edge that ends the cycle. A single load port writes any of the six registers for initialisation, and it wins over a post-update of the same register in the same cycle. Pointer arithmetic wraps modulo 2^16. Each side has an enable, and a disabled side neither asserts its valid strobe nor changes its pointers.

Top module: `dual_agu`

## Requirements
- R1: After reset all six registers read as zero, and both valid strobes are low while the sides are disabled.
- R2: With `x_en` high, `x_valid` is high and `x_addr` equals bits [15:1] of X pointer 0 when `x_sel`=0, or of X pointer 1 when `x_sel`=1; with `x_en` low, `x_valid` is low.
- R3: With `y_en` high, `y_valid` is high and `y_addr` equals bits [15:1] of Y pointer 0 when `y_sel`=0, or of Y pointer 1 when `y_sel`=1; with `y_en` low, `y_valid` is low.
- R4: Mode code 0 (hold) and mode code 3 (reserved) leave the selected pointer unchanged.
- R5: Mode code 1 adds 2 to the selected pointer, and the pointer not selected is unchanged.
- R6: Mode code 2 adds the side's own index register to the selected pointer (X index for X, Y index for Y).
- R7: The address shown in a cycle is the pre-update pointer, and the updated value appears on the bus from the next cycle.
- R8: Pointer updates wrap modulo 2^16 (0xFFFE + 2 gives 0x0000).
- R9: A disabled side leaves its pointers unchanged, whatever its mode field holds.
- R10: With `ld_en` high, `ld_data` is written at the clock edge into the register coded by `ld_sel`: 0 X pointer 0, 1 X pointer 1, 2 X index, 3 Y pointer 0, 4 Y pointer 1, 5 Y index. Codes 6 and 7 write nothing.
- R11: A load to a pointer in the same cycle as a post-update of that pointer stores the load data and discards the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| x_en | input | 1 | X side access enable |
| x_sel | input | 1 | X pointer select |
| x_mode | input | 2 | X post-update mode |
| y_en | input | 1 | Y side access enable |
| y_sel | input | 1 | Y pointer select |
| y_mode | input | 2 | Y post-update mode |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 3 | Register load target code |
| ld_data | input | 16 | Register load value |
| x_addr | output | 15 | X bus word address (byte address bits 15:1) |
| x_valid | output | 1 | X access strobe |
| y_addr | output | 15 | Y bus word address (byte address bits 15:1) |
| y_valid | output | 1 | Y access strobe |

## Verification
The property checks assume that every control input is at a known level in every cycle after the internal reset releases. They also assume that the inputs hold their reset-time zeros until then, since the first post-reset comparison reaches back one cycle. The bench drives all inputs to zero from time zero and changes them only at falling edges, so each rising edge sees one settled set of controls. The arithmetic properties compare the selected pointer over two cycles only when the select bit is unchanged. The bench therefore keeps the select steady across the update sequences and changes it only in hold cycles.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    UPD_HOLD  = 2'd0,
    UPD_STEP  = 2'd1,
    UPD_INDEX = 2'd2,
    UPD_RSVD  = 2'd3
  } upd_mode_e;

  localparam int unsigned SIDES        = 2;
  localparam int unsigned SLOTS        = 3;
  localparam int unsigned NREG         = SIDES * SLOTS;
  localparam int unsigned IDX_SLOT     = 2;
  localparam int unsigned STEP_BYTES   = 2;
endpackage

// File: rtl/agu_side.sv
module agu_side
  import agu_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          en,
  input  logic          sel,
  input  upd_mode_e     mode,
  input  logic [AW-1:0] ptr0,
  input  logic [AW-1:0] ptr1,
  input  logic [AW-1:0] idx,
  output logic [AW-1:1] bus_addr,
  output logic          bus_vld,
  output logic [AW-1:0] cur_ptr,
  output logic          upd_en,
  output logic          upd_sel,
  output logic [AW-1:0] upd_val
);
  localparam logic [AW-1:0] STEP = AW'(STEP_BYTES);

  always_comb begin
    cur_ptr  = sel ? ptr1 : ptr0;
    bus_addr = cur_ptr[AW-1:1];
    bus_vld  = en;
    upd_sel  = sel;
    upd_en   = 1'b0;
    upd_val  = cur_ptr;
    unique case (mode)
      UPD_STEP: begin
        upd_en  = en;
        upd_val = cur_ptr + STEP;
      end
      UPD_INDEX: begin
        upd_en  = en;
        upd_val = cur_ptr + idx;
      end
      default: begin
        upd_en  = 1'b0;
        upd_val = cur_ptr;
      end
    endcase
  end
endmodule

// File: rtl/agu_regfile.sv
module agu_regfile
  import agu_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned LW = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SIDES-1:0]           upd_en,
  input  logic [SIDES-1:0]           upd_sel,
  input  logic [SIDES-1:0][AW-1:0]   upd_val,
  input  logic                       ld_en,
  input  logic [LW-1:0]              ld_sel,
  input  logic [AW-1:0]              ld_data,
  output logic [NREG-1:0][AW-1:0]    regs_q
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam int unsigned SIDE = i / SLOTS;
    localparam int unsigned SLOT = i % SLOTS;

    logic          ld_hit;
    logic          upd_hit;
    logic          we;
    logic [AW-1:0] d;

    always_comb begin
      ld_hit = ld_en && (ld_sel == LW'(i));
      if (SLOT == IDX_SLOT) begin
        upd_hit = 1'b0;
      end else begin
        upd_hit = upd_en[SIDE] && (upd_sel[SIDE] == SLOT[0]);
      end
      we = ld_hit || upd_hit;
      d  = ld_hit ? ld_data : upd_val[SIDE];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[i] <= '0;
      end else if (we) begin
        regs_q[i] <= d;
      end
    end

    // R11
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && ld_sel == LW'(i)) |=> regs_q[i] == $past(ld_data));

    // R9
    untouched_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_en && ld_sel == LW'(i)) && !upd_hit |=> $stable(regs_q[i]));
  end
endmodule

// File: rtl/dual_agu.sv
module dual_agu
  import agu_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          x_en,
  input  logic          x_sel,
  input  logic [1:0]    x_mode,
  input  logic          y_en,
  input  logic          y_sel,
  input  logic [1:0]    y_mode,
  input  logic          ld_en,
  input  logic [LW-1:0] ld_sel,
  input  logic [AW-1:0] ld_data,
  output logic [AW-2:0] x_addr,
  output logic          x_valid,
  output logic [AW-2:0] y_addr,
  output logic          y_valid
);
  logic [1:0] rst_sync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  logic [NREG-1:0][AW-1:0]  regs;
  logic [SIDES-1:0]         upd_en;
  logic [SIDES-1:0]         upd_sel;
  logic [SIDES-1:0][AW-1:0] upd_val;
  logic [SIDES-1:0][AW-1:0] cur;
  logic [SIDES-1:0]         s_en, s_sel, s_vld;
  upd_mode_e                s_mode [SIDES];
  logic [SIDES-1:0][AW-1:1] s_addr;

  always_comb begin
    s_en   = {y_en, x_en};
    s_sel  = {y_sel, x_sel};
    s_mode[0] = upd_mode_e'(x_mode);
    s_mode[1] = upd_mode_e'(y_mode);
  end

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    agu_side #(.AW(AW)) u_side (
      .en      (s_en[s]),
      .sel     (s_sel[s]),
      .mode    (s_mode[s]),
      .ptr0    (regs[s*SLOTS]),
      .ptr1    (regs[s*SLOTS+1]),
      .idx     (regs[s*SLOTS+IDX_SLOT]),
      .bus_addr(s_addr[s]),
      .bus_vld (s_vld[s]),
      .cur_ptr (cur[s]),
      .upd_en  (upd_en[s]),
      .upd_sel (upd_sel[s]),
      .upd_val (upd_val[s])
    );
  end

  agu_regfile #(.AW(AW), .LW(LW)) u_rf (
    .clk    (clk),
    .rst_n  (rst_q),
    .upd_en (upd_en),
    .upd_sel(upd_sel),
    .upd_val(upd_val),
    .ld_en  (ld_en),
    .ld_sel (ld_sel),
    .ld_data(ld_data),
    .regs_q (regs)
  );

  assign x_addr  = s_addr[0];
  assign x_valid = s_vld[0];
  assign y_addr  = s_addr[1];
  assign y_valid = s_vld[1];

  // R5
  x_step_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(x_en && x_mode == 2'd1 && !(ld_en && ld_sel == LW'(x_sel)))
     && x_sel == $past(x_sel))
    |-> cur[0] == $past(cur[0]) + AW'(STEP_BYTES));

  // R6
  y_index_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(y_en && y_mode == 2'd2 && !(ld_en && ld_sel == LW'(SLOTS + y_sel)))
     && y_sel == $past(y_sel))
    |-> cur[1] == $past(cur[1]) + $past(regs[SLOTS+IDX_SLOT]));

  // R4
  x_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ($past((x_mode == 2'd0 || x_mode == 2'd3) && !ld_en) && x_sel == $past(x_sel))
    |-> $stable(cur[0]));
endmodule

// File: tb/dual_agu_test.sv
module dual_agu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        x_en = 0, x_sel = 0, y_en = 0, y_sel = 0, ld_en = 0;
  logic [1:0]  x_mode = 0, y_mode = 0;
  logic [2:0]  ld_sel = 0;
  logic [15:0] ld_data = 0;
  logic [14:0] x_addr, y_addr;
  logic        x_valid, y_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [15:0] m [6];

  always #10 clk = ~clk;

  dual_agu uut (
    .clk(clk), .rst_n(rst_n),
    .x_en(x_en), .x_sel(x_sel), .x_mode(x_mode),
    .y_en(y_en), .y_sel(y_sel), .y_mode(y_mode),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .x_addr(x_addr), .x_valid(x_valid), .y_addr(y_addr), .y_valid(y_valid)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, check pre-update outputs, advance model
  task automatic step(string tag, bit xe, bit xs, logic [1:0] xm,
                      bit ye, bit ys, logic [1:0] ym,
                      bit le = 0, logic [2:0] ls = 0, logic [15:0] ld = 0);
    logic [15:0] n [6];
    @(negedge clk);
    x_en = xe; x_sel = xs; x_mode = xm;
    y_en = ye; y_sel = ys; y_mode = ym;
    ld_en = le; ld_sel = ls; ld_data = ld;
    #5;
    chk({tag, " x_valid"}, 32'(x_valid), 32'(xe));
    chk({tag, " y_valid"}, 32'(y_valid), 32'(ye));
    if (xe) chk({tag, " x_addr"}, 32'(x_addr), 32'(m[xs ? 1 : 0][15:1]));
    if (ye) chk({tag, " y_addr"}, 32'(y_addr), 32'(m[ys ? 4 : 3][15:1]));
    for (int i = 0; i < 6; i++) n[i] = m[i];
    if (xe && xm == 2'd1) n[xs ? 1 : 0] = m[xs ? 1 : 0] + 16'd2;
    if (xe && xm == 2'd2) n[xs ? 1 : 0] = m[xs ? 1 : 0] + m[2];
    if (ye && ym == 2'd1) n[ys ? 4 : 3] = m[ys ? 4 : 3] + 16'd2;
    if (ye && ym == 2'd2) n[ys ? 4 : 3] = m[ys ? 4 : 3] + m[5];
    if (le && ls < 3'd6) n[ls] = ld;
    @(posedge clk);
    for (int i = 0; i < 6; i++) m[i] = n[i];
  endtask

  task automatic read_all(string tag);
    step({tag, " X0/Y0"}, 1, 0, 0, 1, 0, 0);
    step({tag, " X1/Y1"}, 1, 1, 0, 1, 1, 0);
  endtask

  task automatic t_reset;
    step("R1 idle", 0, 0, 0, 0, 0, 0);
    read_all("R1");
  endtask

  task automatic t_load;
    step("R10 ld X0", 0, 0, 0, 0, 0, 0, 1, 3'd0, 16'h1000);
    step("R10 ld X1", 0, 0, 0, 0, 0, 0, 1, 3'd1, 16'h2000);
    step("R10 ld XI", 0, 0, 0, 0, 0, 0, 1, 3'd2, 16'h0010);
    step("R10 ld Y0", 0, 0, 0, 0, 0, 0, 1, 3'd3, 16'h3000);
    step("R10 ld Y1", 0, 0, 0, 0, 0, 0, 1, 3'd4, 16'h4000);
    step("R10 ld YI", 0, 0, 0, 0, 0, 0, 1, 3'd5, 16'h0006);
    step("R10 code6", 0, 0, 0, 0, 0, 0, 1, 3'd6, 16'hFFFF);
    step("R10 code7", 0, 0, 0, 0, 0, 0, 1, 3'd7, 16'hFFFF);
    read_all("R10 readback");
  endtask

  task automatic t_select_hold;
    step("R2 R3 R4 hold sel0", 1, 0, 2'd0, 1, 0, 2'd0);
    step("R2 R3 R4 rsvd sel1", 1, 1, 2'd3, 1, 1, 2'd3);
    step("R4 after rsvd", 1, 1, 2'd0, 1, 1, 2'd0);
    step("R2 R3 sel0", 1, 0, 2'd0, 1, 0, 2'd0);
  endtask

  task automatic t_step;
    step("R5 R7 step a", 1, 0, 2'd1, 1, 1, 2'd1);
    step("R5 R7 step b", 1, 0, 2'd1, 1, 1, 2'd1);
    step("R5 R7 after", 1, 0, 2'd0, 1, 1, 2'd0);
    read_all("R5 other ptr");
  endtask

  task automatic t_index;
    step("R6 index a", 1, 1, 2'd2, 1, 0, 2'd2);
    step("R6 index b", 1, 1, 2'd2, 1, 0, 2'd2);
    step("R6 after", 1, 1, 2'd0, 1, 0, 2'd0);
    read_all("R6 all");
  endtask

  task automatic t_wrap;
    step("R8 ld X0", 0, 0, 0, 0, 0, 0, 1, 3'd0, 16'hFFFE);
    step("R8 ld Y1", 0, 0, 0, 0, 0, 0, 1, 3'd4, 16'hFFFC);
    step("R8 wrap", 1, 0, 2'd1, 1, 1, 2'd2);
    step("R8 after", 1, 0, 2'd0, 1, 1, 2'd0);
    chk("R8 x wrapped to 0", 32'(x_addr), 32'h0);
    chk("R8 y wrapped to 2", 32'(y_addr), 32'h1);
  endtask

  task automatic t_disable;
    step("R9 off step", 0, 0, 2'd1, 0, 1, 2'd2);
    step("R9 off index", 0, 1, 2'd2, 0, 0, 2'd1);
    read_all("R9 unchanged");
  endtask

  task automatic t_prio;
    step("R11 X ld+step", 1, 0, 2'd1, 1, 0, 2'd2, 1, 3'd0, 16'h0ABC);
    step("R11 X after", 1, 0, 2'd0, 1, 0, 2'd0);
    chk("R11 x load won", 32'(x_addr), 32'(16'h0ABC >> 1));
    step("R11 Y ld+idx", 1, 0, 2'd2, 1, 0, 2'd2, 1, 3'd3, 16'h5554);
    step("R11 Y after", 1, 0, 2'd0, 1, 0, 2'd0);
    chk("R11 y load won", 32'(y_addr), 32'(16'h5554 >> 1));
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 6; i++) m[i] = 16'h0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_load();
    t_select_hold();
    t_step();
    t_index();
    t_wrap();
    t_disable();
    t_prio();
    finish_run();
  end
endmodule